// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each issued operation takes two 16-bit operands, an operation code and an accumulator select, and updates one of two 40-bit accumulators. The available operations are:

- multiply, negated multiply, multiply-accumulate and multiply-subtract;
- the square of the operand difference, plain or accumulated;
- clearing an accumulator;
- adding, subtracting or negating with the other accumulator as operand.

A single 17x17 signed multiplier serves signed, unsigned and fractional operands. The product is registered in a first stage and the accumulator is written in a second stage. Back-to-back operations on the same accumulator are therefore allowed.

Each accumulator has its own saturation enable. A shared mode bit picks the clamp range: either the 32-bit signed range or the full 40-bit range. A combinational read-out port selects either accumulator and rounds it to a 16-bit word. Rounding is conventional (ties away upward) or convergent (ties to even), and the word can optionally be saturated to the 16-bit range.

Top module: `mac_engine`

## Requirements
- R1: While reset is asserted and right after it, both accumulators read 0 and `rd_word` reads 0.
- R2: An operation presented with `in_valid` high at a rising clock edge is visible on `acc_a`/`acc_b` after the second rising edge, and not after the first. With `in_valid` low nothing changes, whatever the other inputs are.
- R3: Op code 2 (multiply) loads the selected accumulator with x*y, sign-extended to 40 bits. `acc_sel` 0 picks accumulator A and 1 picks B. `signed_mode` 1 treats both operands as two's complement and 0 treats them as unsigned. The unselected accumulator never changes.
- R4: With `frac_mode` 1 the product is doubled. In signed fractional mode, 0x8000 times 0x8000 yields 0x00_7FFF_FFFF.
- R5: Op code 3 loads -x*y. Op code 4 adds x*y to the selected accumulator. Op code 5 subtracts x*y from it.
- R6: Op code 6 loads (x-y)^2 and op code 7 adds (x-y)^2. In both, the difference is taken modulo 2^16 and read as signed.
- R7: Op code 1 clears the selected accumulator to 0.
- R8: Op code 8 adds the other accumulator to the selected one. Op code 9 subtracts the other from the selected one. Op code 10 negates the selected one.
- R9: With the selected accumulator's saturation enable high and `sat_wide` 0, results are clamped to [0xFF_8000_0000, 0x00_7FFF_FFFF]. With the enable low, results wrap modulo 2^40.
- R10: With the enable high and `sat_wide` 1, results beyond the 40-bit signed range clamp to 0x7F_FFFF_FFFF or 0x80_0000_0000. Values beyond 32 bits but inside 40 bits pass unchanged.
- R11: With `round_even` 0, `rd_word` is bits 31:16 of (accumulator + 0x8000).
- R12: With `round_even` 1, the read-out rounds the same way except on a tie (low 16 bits equal 0x8000). On a tie it rounds so that result bit 0 (accumulator bit 16 after rounding) is even.
- R13: With `sat_out_en` 1, a rounded value outside the 32-bit signed range reads out as 0x7FFF or 0x8000. With `sat_out_en` 0, the read-out is the raw bits 31:16.
- R14: Op code 0 and op codes 11 to 15 leave both accumulators unchanged, even with saturation enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issues the operation on the current edge |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| frac_mode | input | 1 | 1 = fractional product (doubled) |
| signed_mode | input | 1 | 1 = signed operands, 0 = unsigned |
| sat_en_a | input | 1 | Saturation enable for accumulator A |
| sat_en_b | input | 1 | Saturation enable for accumulator B |
| sat_wide | input | 1 | 1 = clamp at 40 bits, 0 = clamp at 32 bits |
| round_even | input | 1 | 1 = convergent rounding, 0 = conventional |
| sat_out_en | input | 1 | Saturates the 16-bit read-out |
| rd_sel | input | 1 | Read-out source, 0 = A, 1 = B |
| rd_word | output | 16 | Rounded 16-bit read-out |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |

## Verification
The hardest case to reach from the ports is the 40-bit clamp. A single product is at most about 2^33, so no one operation gets close to 2^39. The stimulus first loads A with the largest fractional product. It then doubles A repeatedly: clear B, add A into B, then add B into A. After eight doublings A sits just below the 40-bit limit, and the ninth must clamp. One more addition with saturation off shows the wrap. The rounding ties are reached by loading exact integer products such as 1*0x8000 and 3*0x8000 in unsigned mode.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_CLR   = 4'h1,
        OP_MPY   = 4'h2,
        OP_MPYN  = 4'h3,
        OP_MAC   = 4'h4,
        OP_MSC   = 4'h5,
        OP_SQD   = 4'h6,
        OP_SQDAC = 4'h7,
        OP_AADD  = 4'h8,
        OP_ASUB  = 4'h9,
        OP_ANEG  = 4'hA
    } op_e;

    function automatic logic uses_diff(input op_e o);
        return (o == OP_SQD) || (o == OP_SQDAC);
    endfunction

endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
// Product unit: one signed (DW+1)x(DW+1) multiply for signed, unsigned,
// fractional and squared-difference operands.
module mac_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          sqd_i,
    input  logic          frac_i,
    input  logic          sgn_i,
    output logic [AW-1:0] prod_o
);
    localparam int PW = 2*DW + 2;
    localparam logic [DW-1:0] MIN_OP   = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] FRAC_MAX = (PW'(1) << (2*DW-1)) - PW'(1);

    logic [DW-1:0]        diff, opa, opb;
    logic                 as_signed, clip;
    logic signed [PW-1:0] ext_a, ext_b, raw;
    logic [PW-1:0]        scaled, res;

    always_comb begin
        diff      = x_i - y_i;
        opa       = sqd_i ? diff : x_i;
        opb       = sqd_i ? diff : y_i;
        as_signed = sqd_i | sgn_i;
        ext_a     = {{(PW-DW){as_signed & opa[DW-1]}}, opa};
        ext_b     = {{(PW-DW){as_signed & opb[DW-1]}}, opb};
        raw       = ext_a * ext_b;
        scaled    = frac_i ? {raw[PW-2:0], 1'b0} : raw;
        // -1.0 * -1.0 in fractional signed mode would give +1.0: clip it
        clip      = frac_i & as_signed & (opa == MIN_OP) & (opb == MIN_OP);
        res       = clip ? FRAC_MAX : scaled;
        prod_o    = {{(AW-PW){res[PW-1]}}, res};
    end
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
// Next-value unit for one accumulator: add/subtract, then clamp.
module mac_accum
    import mac_pkg::*;
#(
    parameter int AW = 40,
    parameter int NW = 32
) (
    input  op_e           op_i,
    input  logic [AW-1:0] self_i,
    input  logic [AW-1:0] other_i,
    input  logic [AW-1:0] prod_i,
    input  logic          sat_en_i,
    input  logic          wide_i,
    output logic [AW-1:0] nxt_o
);
    localparam int TOPW = AW - NW + 2;
    localparam logic [AW-1:0] WIDE_MAX   = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] WIDE_MIN   = {1'b1, {(AW-1){1'b0}}};
    localparam logic [AW-1:0] NARROW_MAX = {{(AW-NW+1){1'b0}}, {(NW-1){1'b1}}};
    localparam logic [AW-1:0] NARROW_MIN = {{(AW-NW+1){1'b1}}, {(NW-1){1'b0}}};

    logic [AW:0]     s_ext, o_ext, p_ext, sum;
    logic            hold;
    logic [TOPW-1:0] top;

    always_comb begin
        s_ext = {self_i[AW-1], self_i};
        o_ext = {other_i[AW-1], other_i};
        p_ext = {prod_i[AW-1], prod_i};
        hold  = 1'b0;
        unique case (op_i)
            OP_CLR:   sum = '0;
            OP_MPY:   sum = p_ext;
            OP_SQD:   sum = p_ext;
            OP_MPYN:  sum = '0 - p_ext;
            OP_MAC:   sum = s_ext + p_ext;
            OP_SQDAC: sum = s_ext + p_ext;
            OP_MSC:   sum = s_ext - p_ext;
            OP_AADD:  sum = s_ext + o_ext;
            OP_ASUB:  sum = s_ext - o_ext;
            OP_ANEG:  sum = '0 - s_ext;
            default: begin
                sum  = s_ext;
                hold = 1'b1;
            end
        endcase

        top   = sum[AW:NW-1];
        nxt_o = sum[AW-1:0];
        if (sat_en_i && !hold) begin
            if (wide_i) begin
                if (sum[AW] != sum[AW-1])
                    nxt_o = sum[AW] ? WIDE_MIN : WIDE_MAX;
            end else if (!((&top) || !(|top))) begin
                nxt_o = sum[AW] ? NARROW_MIN : NARROW_MAX;
            end
        end
    end
endmodule

// File: rtl/mac_readout.sv
`timescale 1ns/1ps
// Rounds an accumulator to DW bits taken from bits [2*DW-1:DW].
module mac_readout #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc_i,
    input  logic          conv_i,
    input  logic          sat_i,
    output logic [DW-1:0] word_o
);
    localparam int HW = AW - DW + 1;
    localparam logic [DW-1:0] W_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] W_MIN = {1'b1, {(DW-1){1'b0}}};

    logic          tie_keep, inc, fits;
    logic [HW-1:0] hi;

    always_comb begin
        // adding half an LSB only carries into the upper part when bit DW-1 is set
        tie_keep = conv_i & ~acc_i[DW] & (acc_i[DW-2:0] == '0);
        inc      = acc_i[DW-1] & ~tie_keep;
        hi       = {acc_i[AW-1], acc_i[AW-1:DW]} + HW'(inc);
        fits     = (&hi[HW-1:DW-1]) | ~(|hi[HW-1:DW-1]);
        if (sat_i && !fits)
            word_o = hi[HW-1] ? W_MIN : W_MAX;
        else
            word_o = hi[DW-1:0];
    end
endmodule

// File: rtl/mac_engine.sv
`timescale 1ns/1ps
module mac_engine
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic          acc_sel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic          frac_mode,
    input  logic          signed_mode,
    input  logic          sat_en_a,
    input  logic          sat_en_b,
    input  logic          sat_wide,
    input  logic          round_even,
    input  logic          sat_out_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_word,
    output logic [AW-1:0] acc_a,
    output logic [AW-1:0] acc_b
);
    localparam int NACC = 2;
    localparam int NW   = 2*DW;

    typedef struct packed {
        logic                      v;
        op_e                       op;
        logic                      sel;
        logic [AW-1:0]             prod;
        logic [NACC-1:0]           sat;
        logic                      wide;
        logic [NACC-1:0][AW-1:0]   acc;
    } state_t;

    state_t                    st_d, st_q;
    op_e                       op_in;
    logic [AW-1:0]             prod;
    logic [NACC-1:0][AW-1:0]   acc_nxt;

    assign op_in = op_e'(op);

    mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x_i    (x_in),
        .y_i    (y_in),
        .sqd_i  (uses_diff(op_in)),
        .frac_i (frac_mode),
        .sgn_i  (signed_mode),
        .prod_o (prod)
    );

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        mac_accum #(.AW(AW), .NW(NW)) u_accum (
            .op_i     (st_q.op),
            .self_i   (st_q.acc[g]),
            .other_i  (st_q.acc[NACC-1-g]),
            .prod_i   (st_q.prod),
            .sat_en_i (st_q.sat[g]),
            .wide_i   (st_q.wide),
            .nxt_o    (acc_nxt[g])
        );
    end

    mac_readout #(.DW(DW), .AW(AW)) u_rd (
        .acc_i  (st_q.acc[rd_sel]),
        .conv_i (round_even),
        .sat_i  (sat_out_en),
        .word_o (rd_word)
    );

    always_comb begin
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) begin
            st_d.op   = op_in;
            st_d.sel  = acc_sel;
            st_d.prod = prod;
            st_d.sat  = {sat_en_b, sat_en_a};
            st_d.wide = sat_wide;
        end
        for (int i = 0; i < NACC; i++) begin
            if (st_q.v && (st_q.sel == i[0]))
                st_d.acc[i] = acc_nxt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_a = st_q.acc[0];
    assign acc_b = st_q.acc[1];
endmodule

// File: rtl/mac_engine_chk.sv
`timescale 1ns/1ps
module mac_engine_chk
    import mac_pkg::*;
#(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    op,
    input logic          acc_sel,
    input logic          sat_en_a,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_a == '0) && (acc_b == '0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> $stable(acc_a) && $stable(acc_b));

    a_r3_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_sel) |=> ##1 $stable(acc_a));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CLR && !acc_sel) |=> ##1 (acc_a == '0));

    a_r8_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ANEG && !acc_sel && !sat_en_a)
        |=> ##1 (acc_a == (~$past(acc_a) + 1'b1)));

    a_r14_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_NOP) |=> ##1 ($stable(acc_a) && $stable(acc_b)));
endmodule

bind mac_engine mac_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .acc_sel  (acc_sel),
    .sat_en_a (sat_en_a),
    .acc_a    (acc_a),
    .acc_b    (acc_b)
);

// File: tb/mac_engine_tb_top.sv
`timescale 1ns/1ps
module mac_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'h0;
    logic        acc_sel = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        frac_mode = 1'b0, signed_mode = 1'b1;
    logic        sat_en_a = 1'b0, sat_en_b = 1'b0, sat_wide = 1'b0;
    logic        round_even = 1'b0, sat_out_en = 1'b0, rd_sel = 1'b0;
    logic [15:0] rd_word;
    logic [39:0] acc_a, acc_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mac_engine dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
        .x_in(x_in), .y_in(y_in), .frac_mode(frac_mode), .signed_mode(signed_mode),
        .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_wide(sat_wide),
        .round_even(round_even), .sat_out_en(sat_out_en), .rd_sel(rd_sel),
        .rd_word(rd_word), .acc_a(acc_a), .acc_b(acc_b)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        sel;
        logic [15:0] x;
        logic [15:0] y;
        logic        frac;
        logic        sgn;
        logic        sa;
        logic        sb;
        logic        wide;
        logic [39:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    // fields: op sel x y frac sgn sat_a sat_b wide expected req
    localparam vec_t VECS [0:NV-1] = '{
        '{4'h2, 1'b0, 16'h0003, 16'hFFFB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_FFFF_FFF1, 8'd3},  // R3 signed
        '{4'h2, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_FFFE_0001, 8'd3},  // R3 unsigned
        '{4'h4, 1'b0, 16'h0002, 16'h000A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_0005, 8'd5},  // R5 MAC
        '{4'h5, 1'b0, 16'h0004, 16'h0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_FFFF_FFF5, 8'd5},  // R5 MSC
        '{4'h3, 1'b1, 16'h0007, 16'h0006, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_FFFF_FFD6, 8'd5},  // R5 MPYN
        '{4'h6, 1'b0, 16'h000A, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_0031, 8'd6},  // R6
        '{4'h7, 1'b0, 16'h0003, 16'h000A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_0062, 8'd6},  // R6 neg diff
        '{4'h2, 1'b0, 16'h4000, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_2000_0000, 8'd4},  // R4
        '{4'h2, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_7FFF_FFFF, 8'd4},  // R4 clip
        '{4'h8, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_7FFF_FFD5, 8'd8},  // R8 add
        '{4'h9, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_8000_0001, 8'd8},  // R8 sub
        '{4'hA, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_8000_002B, 8'd8},  // R8 neg
        '{4'h1, 1'b1, 16'h1111, 16'h2222, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_0000, 8'd7},  // R7
        '{4'h0, 1'b0, 16'h1234, 16'h5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_8000_002B, 8'd14}, // R14
        '{4'hB, 1'b0, 16'h1234, 16'h5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_8000_002B, 8'd14}, // R14 unused code
        '{4'h2, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 8'd4},  // R4 unsigned
        '{4'h4, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'h00_7FFF_FFFF, 8'd9},  // R9 clamp hi
        '{4'h4, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 8'd9},  // R9 off
        '{4'h9, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 40'hFF_8000_0000, 8'd9},  // R9 edge
        '{4'h5, 1'b1, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 40'hFF_8000_0000, 8'd9},  // R9 clamp lo
        '{4'h4, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 40'h00_8000_0001, 8'd10}  // R10 passes
    };

    task automatic check(input int req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic s, input logic [15:0] xv, input logic [15:0] yv,
                         input logic fr, input logic sg, input logic sa, input logic sb, input logic wd);
        @(negedge clk);
        op = o; acc_sel = s; x_in = xv; y_in = yv;
        frac_mode = fr; signed_mode = sg; sat_en_a = sa; sat_en_b = sb; sat_wide = wd;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, acc_a, 40'h0);
        check(1, acc_b, 40'h0);
        check(1, {24'h0, rd_word}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, acc_a, 40'h0);

        // R2: two-edge latency, in_valid low ignored
        op = 4'h2; acc_sel = 1'b0; x_in = 16'd2; y_in = 16'd3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(2, acc_a, 40'h0);
        @(negedge clk);
        check(2, acc_a, 40'h6);
        x_in = 16'd9; y_in = 16'd9;
        repeat (3) @(negedge clk);
        check(2, acc_a, 40'h6);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].sel, VECS[i].x, VECS[i].y, VECS[i].frac, VECS[i].sgn,
                  VECS[i].sa, VECS[i].sb, VECS[i].wide);
            check(int'(VECS[i].req), VECS[i].sel ? acc_b : acc_a, VECS[i].exp);
        end

        // R10: drive A to the 40-bit limit by repeated doubling through B
        issue(4'h2, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int n = 1; n <= 9; n++) begin
            issue(4'h1, 1'b1, 16'h0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
            issue(4'h8, 1'b1, 16'h0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
            issue(4'h8, 1'b0, 16'h0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
            if (n == 8) check(10, acc_a, 40'h7F_FFFF_FF00);
        end
        check(10, acc_a, 40'h7F_FFFF_FFFF);
        // R9: saturation disabled wraps modulo 2^40
        issue(4'h8, 1'b0, 16'h0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check(9, acc_a, 40'hFF_FFFF_FEFF);

        // R11 / R12: rounding
        rd_sel = 1'b0; sat_out_en = 1'b0;
        issue(4'h2, 1'b0, 16'h0001, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        round_even = 1'b0; #0.1;
        check(11, {24'h0, rd_word}, 40'h1);
        round_even = 1'b1; #0.1;
        check(12, {24'h0, rd_word}, 40'h0);
        issue(4'h2, 1'b0, 16'h0003, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(12, {24'h0, rd_word}, 40'h2);
        round_even = 1'b0; #0.1;
        check(11, {24'h0, rd_word}, 40'h2);
        issue(4'h2, 1'b0, 16'h0001, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(11, {24'h0, rd_word}, 40'h0);

        // R13: read-out saturation
        issue(4'h2, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        sat_out_en = 1'b1; #0.1;
        check(13, {24'h0, rd_word}, 40'h7FFF);
        sat_out_en = 1'b0; #0.1;
        check(13, {24'h0, rd_word}, 40'h8000);
        issue(4'h3, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(5, acc_b, 40'hFE_0003_FFFE);
        rd_sel = 1'b1; sat_out_en = 1'b1; #0.1;
        check(13, {24'h0, rd_word}, 40'h8000);
        sat_out_en = 1'b0; #0.1;
        check(13, {24'h0, rd_word}, 40'h0004);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule